// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Controller

This block is a register-mapped sequencer that sits in front of a one-time-programmable array of 32-bit fuse words. Software selects a fuse word address, loads burn data and a pulse length, then writes a command into the control register. The command can be a single-word read, a burn, or a sense pass. A state field in the same register shows the command's progress. Every burn writes the data word to the addressed location and to the next location, which acts as its redundant copy. A fuse bit can only go from 0 to 1, so a burn ORs the data into each stored word.

A sense pass reads the lowest fuse words one at a time into a bank of read-only shadow registers in the upper part of the register window. When the pass ends, a done flag is set. Four controls protect the array and the registers:
- A power-down bit stops reads and burns.
- A sticky programming-disable bit stops all later burns.
- A sticky write lock freezes the whole register file.
- A sticky key lockout makes a protected range of shadow words read as all ones.

The fuse macro is outside the block. Its read interface has one cycle of latency, and it ORs the write data into the addressed word on each clock edge where the program strobe is high.

Top module: `fuse_ctl_top`

## Requirements
- R1: After reset the control register (word 0) reads 0x0404_0000: state 4 (idle) in bits 20:16, power-down set in bit 26, sense-done (bit 30) clear. The read-data register (word 2) and every shadow word read 0.
- R2: Writing command 1 in control bits 1:0, with bit 26 of the same write clear, reads the fuse word whose address is in word 1. The result appears in word 2.
- R3: Command 2 ORs the data in word 3 into fuse word A and into word A+1, where A is the address in word 1. A+1 wraps modulo the array depth.
- R4: During a burn, the program strobe stays high for T cycles on word A and then for T cycles on word A+1. T is the value in word 4, and a value of 0 counts as 1.
- R5: A read or burn command written with bit 26 set is refused. The state stays idle, word 2 does not change, and no fuse changes.
- R6: Command 3 copies fuse words 0 to 15 into shadow words 0x40 to 0x4F and then sets bit 30. Bit 30 clears when a new sense is accepted. Shadow words do not change between sense passes.
- R7: Writing 1 to bit 0 of word 5 refuses every later burn until reset. Writing 0 afterwards does not clear it. Reads still work.
- R8: Writing 1 to bit 0 of word 6 blocks every later register write until reset, including command writes.
- R9: Writing 1 to bit 0 of word 7 makes shadow words 0x48 to 0x4B read 0xFFFF_FFFF until reset. Other shadow words read normally.
- R10: A command written while the state is not idle is ignored.
- R11: The state field reads a value other than 4 while any command runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 8 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational from addr_i) |
| fuse_addr_o | output | 7 | Fuse word address |
| fuse_rd_o | output | 1 | Fuse read strobe; data returned the next cycle |
| fuse_pgm_o | output | 1 | Fuse program strobe |
| fuse_wdata_o | output | 32 | Bits to burn |
| fuse_rdata_i | input | 32 | Fuse read data |

## Verification
The bench targets these corner cases, and names the failure each one would expose:
- **Wrap of the redundant copy from the last word to word 0.** A design that gets this wrong would burn an out-of-range word, or skip the copy.
- **Pulse length of zero.** A wrong design would hang, or burn for 2^16 cycles.
- **Commands written in the middle of a burn.** A design that restarts on them would clobber the read data or raise sense-done early.
- **Stale shadow contents after a burn, and sense-done clearing on a second pass.** These show whether the shadows change only on a sense.
- **The sticky bits after a software attempt to clear them.** A design that is not sticky would allow burns again, or unlock the register file.
- **Shadow words on both sides of the key range.** These catch off-by-one errors in the lockout mask.

// File: rtl/fuse_ctl_pkg.sv
package fuse_ctl_pkg;

  typedef enum logic [4:0] {
    ST_RD_REQ = 5'd1,
    ST_PGM_A  = 5'd2,
    ST_SN_REQ = 5'd3,
    ST_IDLE   = 5'd4,
    ST_RD_CAP = 5'd9,
    ST_PGM_B  = 5'd10,
    ST_SN_CAP = 5'd11
  } st_e;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_RD    = 2'd1,
    CMD_PGM   = 2'd2,
    CMD_SENSE = 2'd3
  } cmd_e;

  localparam int OFS_CTRL    = 0;
  localparam int OFS_FADDR   = 1;
  localparam int OFS_RDATA   = 2;
  localparam int OFS_WDATA   = 3;
  localparam int OFS_PULSE   = 4;
  localparam int OFS_PGMDIS  = 5;
  localparam int OFS_WLOCK   = 6;
  localparam int OFS_KEYLOCK = 7;

  localparam int CTRL_ST_LSB = 16;
  localparam int CTRL_ST_MSB = 20;
  localparam int CTRL_PD_BIT = 26;
  localparam int CTRL_SD_BIT = 30;

endpackage

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_ctl_pkg::*;
#(
  parameter int FUSE_AW = 7,
  parameter int DW      = 32,
  parameter int TW      = 16,
  parameter int NSH     = 16,
  localparam int SIW    = (NSH > 1) ? $clog2(NSH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         cmd_i,
  input  logic [FUSE_AW-1:0] addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [TW-1:0]      plen_i,
  output st_e                state_o,
  output logic [FUSE_AW-1:0] fuse_addr_o,
  output logic               fuse_rd_o,
  output logic               fuse_pgm_o,
  output logic [DW-1:0]      fuse_wdata_o,
  input  logic [DW-1:0]      fuse_rdata_i,
  output logic               rd_valid_o,
  output logic [DW-1:0]      rd_data_o,
  output logic               sh_we_o,
  output logic [SIW-1:0]     sh_idx_o,
  output logic [DW-1:0]      sh_data_o,
  output logic               sense_done_o
);

  st_e                st_q;
  logic [FUSE_AW-1:0] addr_q;
  logic [DW-1:0]      data_q;
  logic [TW-1:0]      cnt_q, plen_q;
  logic [SIW-1:0]     idx_q;
  logic               last_idx;

  assign last_idx = (idx_q == SIW'(NSH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      plen_q <= '0;
      idx_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          addr_q <= addr_i;
          data_q <= wdata_i;
          plen_q <= plen_i;
          cnt_q  <= (plen_i == '0) ? '0 : plen_i - TW'(1);
          idx_q  <= '0;
          case (cmd_e'(cmd_i))
            CMD_RD:    st_q <= ST_RD_REQ;
            CMD_PGM:   st_q <= ST_PGM_A;
            CMD_SENSE: st_q <= ST_SN_REQ;
            default:   st_q <= ST_IDLE;
          endcase
        end
        ST_RD_REQ: st_q <= ST_RD_CAP;
        ST_RD_CAP: st_q <= ST_IDLE;
        ST_PGM_A: begin
          if (cnt_q == '0) begin
            st_q  <= ST_PGM_B;
            cnt_q <= (plen_q == '0) ? '0 : plen_q - TW'(1);
          end else begin
            cnt_q <= cnt_q - TW'(1);
          end
        end
        ST_PGM_B: begin
          if (cnt_q == '0) st_q <= ST_IDLE;
          else             cnt_q <= cnt_q - TW'(1);
        end
        ST_SN_REQ: st_q <= ST_SN_CAP;
        ST_SN_CAP: begin
          if (last_idx) st_q <= ST_IDLE;
          else begin
            idx_q <= idx_q + SIW'(1);
            st_q  <= ST_SN_REQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    fuse_addr_o = addr_q;
    if (st_q == ST_SN_REQ) fuse_addr_o = FUSE_AW'(idx_q);
    else if (st_q == ST_PGM_B) fuse_addr_o = addr_q + FUSE_AW'(1);
  end

  assign state_o      = st_q;
  assign fuse_rd_o    = (st_q == ST_RD_REQ) || (st_q == ST_SN_REQ);
  assign fuse_pgm_o   = (st_q == ST_PGM_A) || (st_q == ST_PGM_B);
  assign fuse_wdata_o = data_q;
  assign rd_valid_o   = (st_q == ST_RD_CAP);
  assign rd_data_o    = fuse_rdata_i;
  assign sh_we_o      = (st_q == ST_SN_CAP);
  assign sh_idx_o     = idx_q;
  assign sh_data_o    = fuse_rdata_i;
  assign sense_done_o = (st_q == ST_SN_CAP) && last_idx;

  AST_BURN_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_pgm_o && $past(fuse_pgm_o) && (fuse_addr_o != $past(fuse_addr_o)))
      |-> (fuse_addr_o == $past(fuse_addr_o) + FUSE_AW'(1))); // R3

  AST_SENSE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_we_o && !$past(st_q == ST_SN_REQ)) |-> 1'b0); // R6

endmodule

// File: rtl/fuse_shadow.sv
module fuse_shadow #(
  parameter int NSH  = 16,
  parameter int DW   = 32,
  localparam int SIW = (NSH > 1) ? $clog2(NSH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [SIW-1:0] widx_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [SIW-1:0] ridx_i,
  output logic [DW-1:0]  rdata_o
);

  logic [DW-1:0] mem_q [NSH];

  for (genvar i = 0; i < NSH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[i] <= '0;
      else if (we_i && (widx_i == SIW'(i)))     mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];

endmodule

// File: rtl/fuse_regs.sv
module fuse_regs
  import fuse_ctl_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int FUSE_AW = 7,
  parameter int TW      = 16,
  parameter int NSH     = 16,
  parameter int SH_OFS  = 64,
  parameter int KEY_LO  = 8,
  parameter int KEY_HI  = 11,
  localparam int SIW    = (NSH > 1) ? $clog2(NSH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  st_e                state_i,
  input  logic               rd_valid_i,
  input  logic [DW-1:0]      rd_data_i,
  input  logic               sense_done_i,
  input  logic [DW-1:0]      sh_rdata_i,
  output logic [SIW-1:0]     sh_ridx_o,
  output logic               start_o,
  output logic [1:0]         cmd_o,
  output logic [FUSE_AW-1:0] faddr_o,
  output logic [DW-1:0]      fwdata_o,
  output logic [TW-1:0]      plen_o,
  output logic               pd_o,
  output logic               pgm_dis_o
);

  logic               wr, ctrl_wr, new_pd, allow;
  logic               pd_q, sd_q, pgm_dis_q, wlock_q, key_q;
  logic [FUSE_AW-1:0] fa_q;
  logic [DW-1:0]      wd_q, rd_q;
  logic [TW-1:0]      plen_q;
  logic [AW-1:0]      sh_off;
  logic               in_sh, is_key;
  cmd_e               cmd;

  assign wr      = req_i && we_i && !wlock_q;
  assign ctrl_wr = wr && (addr_i == AW'(OFS_CTRL));
  assign cmd     = cmd_e'(wdata_i[1:0]);
  assign new_pd  = wdata_i[CTRL_PD_BIT];

  always_comb begin
    case (cmd)
      CMD_RD:    allow = !new_pd;
      CMD_PGM:   allow = !new_pd && !pgm_dis_q;
      CMD_SENSE: allow = 1'b1;
      default:   allow = 1'b0;
    endcase
  end

  assign start_o = ctrl_wr && allow && (state_i == ST_IDLE);
  assign cmd_o   = wdata_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q      <= 1'b1;
      sd_q      <= 1'b0;
      pgm_dis_q <= 1'b0;
      wlock_q   <= 1'b0;
      key_q     <= 1'b0;
      fa_q      <= '0;
      wd_q      <= '0;
      rd_q      <= '0;
      plen_q    <= '0;
    end else begin
      if (ctrl_wr) pd_q <= new_pd;
      if (start_o && (cmd == CMD_SENSE)) sd_q <= 1'b0;
      else if (sense_done_i)             sd_q <= 1'b1;
      if (rd_valid_i) rd_q <= rd_data_i;
      if (wr) begin
        case (addr_i)
          AW'(OFS_FADDR):   fa_q   <= wdata_i[FUSE_AW-1:0];
          AW'(OFS_WDATA):   wd_q   <= wdata_i;
          AW'(OFS_PULSE):   plen_q <= wdata_i[TW-1:0];
          AW'(OFS_PGMDIS):  pgm_dis_q <= pgm_dis_q | wdata_i[0];
          AW'(OFS_WLOCK):   wlock_q   <= wlock_q | wdata_i[0];
          AW'(OFS_KEYLOCK): key_q     <= key_q | wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  assign sh_off    = addr_i - AW'(SH_OFS);
  assign sh_ridx_o = sh_off[SIW-1:0];
  assign in_sh     = (addr_i >= AW'(SH_OFS)) && (addr_i < AW'(SH_OFS + NSH));
  assign is_key    = (int'(sh_ridx_o) >= KEY_LO) && (int'(sh_ridx_o) <= KEY_HI);

  always_comb begin
    rdata_o = '0;
    if (in_sh) begin
      rdata_o = (key_q && is_key) ? '1 : sh_rdata_i;
    end else begin
      case (addr_i)
        AW'(OFS_CTRL): begin
          rdata_o[CTRL_ST_MSB:CTRL_ST_LSB] = state_i;
          rdata_o[CTRL_PD_BIT] = pd_q;
          rdata_o[CTRL_SD_BIT] = sd_q;
        end
        AW'(OFS_FADDR):   rdata_o = DW'(fa_q);
        AW'(OFS_RDATA):   rdata_o = rd_q;
        AW'(OFS_WDATA):   rdata_o = wd_q;
        AW'(OFS_PULSE):   rdata_o = DW'(plen_q);
        AW'(OFS_PGMDIS):  rdata_o = DW'(pgm_dis_q);
        AW'(OFS_WLOCK):   rdata_o = DW'(wlock_q);
        AW'(OFS_KEYLOCK): rdata_o = DW'(key_q);
        default: ;
      endcase
    end
  end

  assign faddr_o   = fa_q;
  assign fwdata_o  = wd_q;
  assign plen_o    = plen_q;
  assign pd_o      = pd_q;
  assign pgm_dis_o = pgm_dis_q;

  AST_PGMDIS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pgm_dis_q) |-> pgm_dis_q); // R7

  AST_WLOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wlock_q) |-> wlock_q); // R8

  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wlock_q) |-> ($stable(fa_q) && $stable(wd_q) && $stable(plen_q) && $stable(pd_q))); // R8

  AST_KEYLOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(key_q) |-> key_q); // R9

  AST_SENSE_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sd_q) |-> (state_i == ST_IDLE)); // R6

endmodule

// File: rtl/fuse_ctl_top.sv
module fuse_ctl_top
  import fuse_ctl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int FUSE_AW    = 7,
  parameter int TIME_W     = 16,
  parameter int NUM_SHADOW = 16,
  parameter int SHADOW_OFS = 64,
  parameter int KEY_FIRST  = 8,
  parameter int KEY_LAST   = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [FUSE_AW-1:0] fuse_addr_o,
  output logic               fuse_rd_o,
  output logic               fuse_pgm_o,
  output logic [DATA_W-1:0]  fuse_wdata_o,
  input  logic [DATA_W-1:0]  fuse_rdata_i
);

  localparam int SIW = (NUM_SHADOW > 1) ? $clog2(NUM_SHADOW) : 1;

  st_e                st;
  logic               start, rd_valid, sh_we, sense_done, pd, pgm_dis;
  logic [1:0]         cmd;
  logic [FUSE_AW-1:0] faddr;
  logic [DATA_W-1:0]  fwdata, rd_data, sh_wdata, sh_rdata;
  logic [TIME_W-1:0]  plen;
  logic [SIW-1:0]     sh_widx, sh_ridx;

  fuse_regs #(
    .AW(ADDR_W), .DW(DATA_W), .FUSE_AW(FUSE_AW), .TW(TIME_W), .NSH(NUM_SHADOW),
    .SH_OFS(SHADOW_OFS), .KEY_LO(KEY_FIRST), .KEY_HI(KEY_LAST)
  ) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .state_i(st), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .sense_done_i(sense_done), .sh_rdata_i(sh_rdata), .sh_ridx_o(sh_ridx),
    .start_o(start), .cmd_o(cmd), .faddr_o(faddr), .fwdata_o(fwdata),
    .plen_o(plen), .pd_o(pd), .pgm_dis_o(pgm_dis)
  );

  fuse_seq #(
    .FUSE_AW(FUSE_AW), .DW(DATA_W), .TW(TIME_W), .NSH(NUM_SHADOW)
  ) u_seq (
    .clk_i, .rst_ni, .start_i(start), .cmd_i(cmd), .addr_i(faddr),
    .wdata_i(fwdata), .plen_i(plen), .state_o(st),
    .fuse_addr_o, .fuse_rd_o, .fuse_pgm_o, .fuse_wdata_o, .fuse_rdata_i,
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .sh_we_o(sh_we), .sh_idx_o(sh_widx), .sh_data_o(sh_wdata),
    .sense_done_o(sense_done)
  );

  fuse_shadow #(.NSH(NUM_SHADOW), .DW(DATA_W)) u_shadow (
    .clk_i, .rst_ni, .we_i(sh_we), .widx_i(sh_widx), .wdata_i(sh_wdata),
    .ridx_i(sh_ridx), .rdata_o(sh_rdata)
  );

  AST_RD_PD_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RD_REQ) |-> !pd); // R5

  AST_PGM_PD_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_pgm_o && !$past(fuse_pgm_o)) |-> !pd); // R5

  AST_PGM_DIS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_pgm_o && !$past(fuse_pgm_o)) |-> !pgm_dis); // R7

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fuse_pgm_o && fuse_rd_o)); // R11

endmodule

// File: tb/sim_fuse_ctl_top.sv
module sim_fuse_ctl_top;

  localparam int A_CTRL = 0, A_FADDR = 1, A_RDATA = 2, A_WDATA = 3, A_PULSE = 4;
  localparam int A_PGMDIS = 5, A_WLOCK = 6, A_KEY = 7, A_SH = 64;
  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0]  f_addr;
  logic        f_rd, f_pgm;
  logic [31:0] f_wdata;
  logic [31:0] f_rdata = '0;

  logic [31:0] fmem [DEPTH];
  logic [31:0] emem [DEPTH];
  int unsigned pcnt = 0;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fuse_ctl_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .fuse_addr_o(f_addr), .fuse_rd_o(f_rd),
    .fuse_pgm_o(f_pgm), .fuse_wdata_o(f_wdata), .fuse_rdata_i(f_rdata)
  );

  // behavioural fuse macro
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) fmem[i] <= '0;
    end else begin
      if (f_pgm) fmem[f_addr] <= fmem[f_addr] | f_wdata;
      if (f_rd)  f_rdata <= fmem[f_addr];
    end
  end

  always @(posedge clk) if (f_pgm) pcnt <= pcnt + 1;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 8'(a);
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(A_CTRL, v);
      if (v[20:16] == 5'd4) return;
    end
  endtask

  function automatic int eff_len(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic burn(input int a, input logic [31:0] d, input int pl);
    int unsigned p0;
    wr(A_PULSE, 32'(pl));
    wr(A_WDATA, d);
    wr(A_FADDR, 32'(a));
    p0 = pcnt;
    wr(A_CTRL, 32'h2);
    wait_idle();
    emem[a] |= d;
    emem[(a + 1) % DEPTH] |= d;
    chk("R4 pulse cycles", 32'(pcnt - p0), 32'(2 * eff_len(pl)));
    chk("R3 primary word", fmem[a], emem[a]);
    chk("R3 redundant word", fmem[(a + 1) % DEPTH], emem[(a + 1) % DEPTH]);
  endtask

  task automatic fread(input int a, output logic [31:0] d);
    wr(A_FADDR, 32'(a));
    wr(A_CTRL, 32'h1);
    wait_idle();
    rd(A_RDATA, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, prev;
    int unsigned p0;
    v = $urandom(32'h5EED_0042);
    for (int i = 0; i < DEPTH; i++) emem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0404_0000);
    rd(A_RDATA, v); chk("R1 rdata", v, 32'h0);
    rd(A_SH + 5, v); chk("R1 shadow", v, 32'h0);

    // R5 power-down refuses read and burn
    wr(A_FADDR, 5);
    wr(A_CTRL, 32'h0400_0001);
    rd(A_CTRL, v);  chk("R5 read refused state", v, 32'h0404_0000);
    rd(A_RDATA, v); chk("R5 rdata unchanged", v, 32'h0);
    wr(A_WDATA, 32'hFFFF_0000);
    wr(A_PULSE, 2);
    p0 = pcnt;
    wr(A_CTRL, 32'h0400_0002);
    repeat (10) @(negedge clk);
    chk("R5 no burn strobe", 32'(pcnt - p0), 32'h0);
    chk("R5 fuse untouched", fmem[5], 32'h0);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v);  chk("R5 pd cleared", v, 32'h0004_0000);

    // R3/R4 random burns
    for (int i = 0; i < 12; i++) begin
      int a, pl;
      logic [31:0] d;
      a = int'($urandom % DEPTH);
      d = $urandom;
      pl = int'($urandom % 9);
      burn(a, d, pl);
    end
    burn(127, 32'h8000_0001, 0);   // wrap to word 0
    burn(8, 32'h0000_00A5, 3);
    burn(14, 32'h1234_0000, 1);
    burn(14, 32'h0000_5678, 2);    // OR onto earlier burn

    // R2 reads
    for (int i = 0; i < 6; i++) begin
      int a;
      a = int'($urandom % DEPTH);
      fread(a, v); chk("R2 read word", v, emem[a]);
    end
    fread(0, v);   chk("R2 read wrapped word", v, emem[0]);
    fread(15, v);  chk("R2 read word 15", v, emem[15]);

    // R10/R11 commands during a long burn
    rd(A_RDATA, prev);
    wr(A_PULSE, 40);
    wr(A_WDATA, 32'h00F0_0F00);
    wr(A_FADDR, 30);
    wr(A_CTRL, 32'h2);
    rd(A_CTRL, v); chk("R11 busy state", {31'h0, v[20:16] != 5'd4}, 32'h1);
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h3);
    wait_idle();
    emem[30] |= 32'h00F0_0F00; emem[31] |= 32'h00F0_0F00;
    rd(A_CTRL, v);  chk("R10 sense ignored", {31'h0, v[30]}, 32'h0);
    rd(A_RDATA, v); chk("R10 read ignored", v, prev);
    chk("R10 burn intact", fmem[31], emem[31]);

    // R6 sense
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, v); chk("R11 sense busy", {31'h0, v[20:16] != 5'd4}, 32'h1);
    wait_idle();
    rd(A_CTRL, v); chk("R6 sense done", v, 32'h4004_0000);
    for (int i = 0; i < 16; i++) begin
      rd(A_SH + i, v); chk("R6 shadow copy", v, emem[i]);
    end
    prev = emem[3];
    burn(3, 32'h0C00_0000, 1);
    rd(A_SH + 3, v); chk("R6 shadow stale until sense", v, prev);
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, v); chk("R6 done cleared on accept", {31'h0, v[30]}, 32'h0);
    wait_idle();
    rd(A_SH + 3, v); chk("R6 shadow refreshed", v, emem[3]);

    // R9 key lockout
    wr(A_KEY, 1);
    wr(A_KEY, 0);
    rd(A_SH + 7, v);  chk("R9 below key range", v, emem[7]);
    for (int i = 8; i <= 11; i++) begin
      rd(A_SH + i, v); chk("R9 key masked", v, 32'hFFFF_FFFF);
    end
    rd(A_SH + 12, v); chk("R9 above key range", v, emem[12]);

    // R7 programming disable
    wr(A_PGMDIS, 1);
    wr(A_PGMDIS, 0);
    wr(A_FADDR, 50);
    wr(A_WDATA, 32'hFF);
    p0 = pcnt;
    wr(A_CTRL, 32'h2);
    repeat (20) @(negedge clk);
    chk("R7 no burn strobe", 32'(pcnt - p0), 32'h0);
    chk("R7 fuse untouched", fmem[50], emem[50]);
    fread(50, v); chk("R7 read still works", v, emem[50]);

    // R8 write lock
    wr(A_WLOCK, 1);
    wr(A_WLOCK, 0);
    wr(A_FADDR, 60);
    rd(A_FADDR, v); chk("R8 addr frozen", v, 32'd50);
    wr(A_CTRL, 32'h0400_0003);
    rd(A_CTRL, v);  chk("R8 ctrl frozen", v, 32'h4004_0000);
    wr(A_KEY, 0);
    rd(A_SH + 9, v); chk("R8 key still masked", v, 32'hFFFF_FFFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule